// File: doc/BRIEF.md
# Failure-Pointer Multi-Pattern String Matcher

This block scans a byte stream for several fixed patterns at once. It walks a pattern automaton that keeps only its forward (goto) edges and one fallback pointer per state. Each cycle, the pair of current state and presented character is compared against every stored edge at once. On a hit, the machine takes the edge and consumes the character. On a miss, it moves to the current state's fallback target and tries the same character again on the next cycle. A character can therefore occupy several cycles, so the input side uses a valid/ready handshake that holds the stream back while fallback hops are taken.

The automaton itself is compiled elsewhere and written in through two configuration write ports. One port writes the edge table, where each entry holds a live bit, source state, character and destination state. The other writes the per-state table, where each entry holds a fallback target, a final flag and a one-hot match vector with one bit per pattern. When a goto edge lands on a final state, the block shows that state's match vector for one cycle. The tables are meant to be loaded while the stream is idle.

Top module: `fail_walk_matcher`

## Requirements
- R1: After reset the current state is 0, match_valid is 0, and in_ready is 1 while in_valid is 0. All edge entries are not live and every state entry is zero.
- R2: If in_valid is 1 and a live edge matches {cur_state, in_data}, in_ready is 1 in that cycle and cur_state equals the edge's destination after the clock edge.
- R3: When a goto edge enters a state whose final flag is 1, match_valid is 1 with match_vec equal to that state's vector for exactly the one cycle after the consuming edge. Characters that enter non-final states leave match_valid at 0.
- R4: If in_valid is 1, cur_state is not 0 and no live edge matches, in_ready is 0. After the edge, cur_state equals the fallback target of the old state and in_data is examined again.
- R5: If in_valid is 1, cur_state is 0 and no live edge matches, the character is consumed in one cycle (in_ready is 1) and cur_state stays 0.
- R6: Fallback hops chain. A character that misses at every state along the fallback chain takes one cycle per hop plus one cycle at state 0.
- R7: A character that misses, falls back, and then hits is consumed on the hit cycle. If that hit reaches a final state, a match is reported.
- R8: While in_valid is 0, cur_state holds its value, in_ready is 1 and no match is reported.
- R9: If several live edges match the same {state, character}, the one with the lowest table index decides the destination.
- R10: Writing an edge entry with its live bit at 0 removes that edge from all later lookups.
- R11: Each pattern reports its own one-hot bit as loaded (bit p for pattern p), and matches of different patterns are distinguished by match_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_edge_we | input | 1 | Write strobe for the edge table |
| cfg_edge_idx | input | $clog2(N_EDGES) | Edge entry to write |
| cfg_edge_live | input | 1 | Live bit of the written edge |
| cfg_edge_src | input | $clog2(N_STATES) | Source state of the edge |
| cfg_edge_chr | input | CHAR_W | Character that selects the edge |
| cfg_edge_dst | input | $clog2(N_STATES) | Destination state of the edge |
| cfg_state_we | input | 1 | Write strobe for the state table |
| cfg_state_idx | input | $clog2(N_STATES) | State entry to write |
| cfg_state_fail | input | $clog2(N_STATES) | Fallback target of the state |
| cfg_state_final | input | 1 | Final flag of the state |
| cfg_state_vec | input | N_PATTERNS | One-hot match vector of the state |
| in_valid | input | 1 | Input character is presented |
| in_data | input | CHAR_W | Input character |
| in_ready | output | 1 | Character is consumed at this clock edge |
| cur_state | output | $clog2(N_STATES) | Current automaton state |
| match_valid | output | 1 | One-cycle match indication |
| match_vec | output | N_PATTERNS | Vector of the final state just entered |

## Verification
On every cycle, the in-RTL assertions check the step rules. A goto hit lands on the edge's destination, and a stalled cycle lands on the fallback target. State 0 never stalls, an idle input holds the state, and every match report follows a consumed goto hit. An edge written dead never compares. Only the directed scenarios can show whole-stream outcomes: the cycle count of a multi-hop character, the choice among duplicate edges by index, the exact match vector of each pattern, and the one-cycle length of the match pulse against a hand-built automaton for four patterns.

// File: rtl/fail_walk_pkg.sv
package fail_walk_pkg;

    localparam int DEF_STATES   = 32;
    localparam int DEF_EDGES    = 64;
    localparam int DEF_PATTERNS = 4;
    localparam int DEF_CHAR_W   = 8;

    // What the walker does with the presented character this cycle
    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,   // nothing presented
        STEP_GOTO = 2'd1,   // live edge found, character consumed
        STEP_FAIL = 2'd2,   // no edge, follow fallback, retry character
        STEP_ROOT = 2'd3    // no edge at state 0, drop character
    } step_e;

    function automatic step_e pick_step(input logic valid, input logic hit,
                                        input logic at_root);
        if (!valid)       return STEP_IDLE;
        else if (hit)     return STEP_GOTO;
        else if (at_root) return STEP_ROOT;
        else              return STEP_FAIL;
    endfunction

endpackage

// File: rtl/goto_edge_cam.sv
module goto_edge_cam
    import fail_walk_pkg::*;
#(
    parameter int N_STATES = DEF_STATES,
    parameter int N_EDGES  = DEF_EDGES,
    parameter int CHAR_W   = DEF_CHAR_W,
    localparam int SW = $clog2(N_STATES),
    localparam int EW = $clog2(N_EDGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [EW-1:0]     wr_idx,
    input  logic              wr_live,
    input  logic [SW-1:0]     wr_src,
    input  logic [CHAR_W-1:0] wr_chr,
    input  logic [SW-1:0]     wr_dst,
    input  logic [SW-1:0]     look_state,
    input  logic [CHAR_W-1:0] look_chr,
    output logic              hit,
    output logic [SW-1:0]     hit_dst
);

    logic              live_q [N_EDGES];
    logic [SW-1:0]     src_q  [N_EDGES];
    logic [CHAR_W-1:0] chr_q  [N_EDGES];
    logic [SW-1:0]     dst_q  [N_EDGES];
    logic [N_EDGES-1:0] key_eq;

    for (genvar e = 0; e < N_EDGES; e++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) begin
                live_q[e] <= 1'b0;
                src_q[e]  <= '0;
                chr_q[e]  <= '0;
                dst_q[e]  <= '0;
            end else if (wr_en && (wr_idx == EW'(e))) begin
                live_q[e] <= wr_live;
                src_q[e]  <= wr_src;
                chr_q[e]  <= wr_chr;
                dst_q[e]  <= wr_dst;
            end
        end

        assign key_eq[e] = live_q[e] && (src_q[e] == look_state)
                                     && (chr_q[e] == look_chr);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit     = 1'b0;
        hit_dst = '0;
        for (int i = N_EDGES - 1; i >= 0; i--) begin
            if (key_eq[i]) begin
                hit     = 1'b1;
                hit_dst = dst_q[i];
            end
        end
    end

    // R10: an entry written dead takes no part in the next lookup
    a_r10_dead_edge: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_live) |=> !key_eq[$past(wr_idx)]);

endmodule

// File: rtl/state_attr_table.sv
module state_attr_table
    import fail_walk_pkg::*;
#(
    parameter int N_STATES   = DEF_STATES,
    parameter int N_PATTERNS = DEF_PATTERNS,
    localparam int SW = $clog2(N_STATES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SW-1:0]         wr_idx,
    input  logic [SW-1:0]         wr_fail,
    input  logic                  wr_final,
    input  logic [N_PATTERNS-1:0] wr_vec,
    input  logic [SW-1:0]         rd_cur,
    output logic [SW-1:0]         cur_fail,
    input  logic [SW-1:0]         rd_nxt,
    output logic                  nxt_final,
    output logic [N_PATTERNS-1:0] nxt_vec
);

    logic [SW-1:0]         fail_q  [N_STATES];
    logic                  final_q [N_STATES];
    logic [N_PATTERNS-1:0] vec_q   [N_STATES];

    for (genvar s = 0; s < N_STATES; s++) begin : g_state
        always_ff @(posedge clk) begin
            if (rst) begin
                fail_q[s]  <= '0;
                final_q[s] <= 1'b0;
                vec_q[s]   <= '0;
            end else if (wr_en && (wr_idx == SW'(s))) begin
                fail_q[s]  <= wr_fail;
                final_q[s] <= wr_final;
                vec_q[s]   <= wr_vec;
            end
        end
    end

    assign cur_fail  = fail_q[rd_cur];
    assign nxt_final = final_q[rd_nxt];
    assign nxt_vec   = vec_q[rd_nxt];

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
    import fail_walk_pkg::*;
#(
    parameter int N_STATES   = DEF_STATES,
    parameter int N_PATTERNS = DEF_PATTERNS,
    localparam int SW = $clog2(N_STATES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  hit,
    input  logic [SW-1:0]         hit_dst,
    input  logic [SW-1:0]         fail_tgt,
    input  logic                  dst_final,
    input  logic [N_PATTERNS-1:0] dst_vec,
    output logic [SW-1:0]         cur_state,
    output logic                  match_valid,
    output logic [N_PATTERNS-1:0] match_vec
);

    logic [SW-1:0] cur_q;
    step_e         step;
    logic          report;

    assign step     = pick_step(in_valid, hit, cur_q == '0);
    assign in_ready = (step != STEP_FAIL);
    assign report   = (step == STEP_GOTO) && dst_final;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q       <= '0;
            match_valid <= 1'b0;
            match_vec   <= '0;
        end else begin
            unique case (step)
                STEP_GOTO: cur_q <= hit_dst;
                STEP_FAIL: cur_q <= fail_tgt;
                STEP_ROOT: cur_q <= '0;
                default:   cur_q <= cur_q;
            endcase
            match_valid <= report;
            match_vec   <= report ? dst_vec : '0;
        end
    end

    assign cur_state = cur_q;

    // R2: a consumed hit lands on the edge destination
    a_r2_goto_dest: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && hit) |=> (cur_q == $past(hit_dst)));

    // R4: a stalled cycle lands on the fallback target of the old state
    a_r4_fail_hop: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> (cur_q == $past(fail_tgt)));

    // R5: state 0 never holds the stream back
    a_r5_root_never_stalls: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (cur_q == '0)) |-> in_ready);

    // R8: no character, no movement
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cur_q));

    // R3: every report follows a consumed goto hit
    a_r3_match_cause: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> $past(in_valid && in_ready && hit));

endmodule

// File: rtl/fail_walk_matcher.sv
module fail_walk_matcher
    import fail_walk_pkg::*;
#(
    parameter int N_STATES   = DEF_STATES,
    parameter int N_EDGES    = DEF_EDGES,
    parameter int N_PATTERNS = DEF_PATTERNS,
    parameter int CHAR_W     = DEF_CHAR_W,
    localparam int SW = $clog2(N_STATES),
    localparam int EW = $clog2(N_EDGES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_edge_we,
    input  logic [EW-1:0]         cfg_edge_idx,
    input  logic                  cfg_edge_live,
    input  logic [SW-1:0]         cfg_edge_src,
    input  logic [CHAR_W-1:0]     cfg_edge_chr,
    input  logic [SW-1:0]         cfg_edge_dst,
    input  logic                  cfg_state_we,
    input  logic [SW-1:0]         cfg_state_idx,
    input  logic [SW-1:0]         cfg_state_fail,
    input  logic                  cfg_state_final,
    input  logic [N_PATTERNS-1:0] cfg_state_vec,
    input  logic                  in_valid,
    input  logic [CHAR_W-1:0]     in_data,
    output logic                  in_ready,
    output logic [SW-1:0]         cur_state,
    output logic                  match_valid,
    output logic [N_PATTERNS-1:0] match_vec
);

    logic                  hit;
    logic [SW-1:0]         hit_dst;
    logic [SW-1:0]         fail_tgt;
    logic                  dst_final;
    logic [N_PATTERNS-1:0] dst_vec;

    goto_edge_cam #(
        .N_STATES (N_STATES),
        .N_EDGES  (N_EDGES),
        .CHAR_W   (CHAR_W)
    ) u_cam (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_edge_we),
        .wr_idx     (cfg_edge_idx),
        .wr_live    (cfg_edge_live),
        .wr_src     (cfg_edge_src),
        .wr_chr     (cfg_edge_chr),
        .wr_dst     (cfg_edge_dst),
        .look_state (cur_state),
        .look_chr   (in_data),
        .hit        (hit),
        .hit_dst    (hit_dst)
    );

    state_attr_table #(
        .N_STATES   (N_STATES),
        .N_PATTERNS (N_PATTERNS)
    ) u_attr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_state_we),
        .wr_idx    (cfg_state_idx),
        .wr_fail   (cfg_state_fail),
        .wr_final  (cfg_state_final),
        .wr_vec    (cfg_state_vec),
        .rd_cur    (cur_state),
        .cur_fail  (fail_tgt),
        .rd_nxt    (hit_dst),
        .nxt_final (dst_final),
        .nxt_vec   (dst_vec)
    );

    walk_ctrl #(
        .N_STATES   (N_STATES),
        .N_PATTERNS (N_PATTERNS)
    ) u_walk (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .hit         (hit),
        .hit_dst     (hit_dst),
        .fail_tgt    (fail_tgt),
        .dst_final   (dst_final),
        .dst_vec     (dst_vec),
        .cur_state   (cur_state),
        .match_valid (match_valid),
        .match_vec   (match_vec)
    );

endmodule

// File: tb/test_fail_walk_matcher.sv
module test_fail_walk_matcher;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_edge_we = 1'b0;
    logic [5:0] cfg_edge_idx = '0;
    logic       cfg_edge_live = 1'b0;
    logic [4:0] cfg_edge_src = '0;
    logic [7:0] cfg_edge_chr = '0;
    logic [4:0] cfg_edge_dst = '0;
    logic       cfg_state_we = 1'b0;
    logic [4:0] cfg_state_idx = '0;
    logic [4:0] cfg_state_fail = '0;
    logic       cfg_state_final = 1'b0;
    logic [3:0] cfg_state_vec = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic [4:0] cur_state;
    logic       match_valid;
    logic [3:0] match_vec;

    int total = 0;
    int bad   = 0;
    int last_cycles;
    logic       last_mv;
    logic [3:0] last_vec;

    always #2 clk = ~clk;

    fail_walk_matcher i_fail_walk_matcher (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_edge(input int idx, input logic live, input int src,
                             input byte chr, input int dst);
        cfg_edge_we = 1'b1; cfg_edge_idx = 6'(idx); cfg_edge_live = live;
        cfg_edge_src = 5'(src); cfg_edge_chr = chr; cfg_edge_dst = 5'(dst);
        @(negedge clk);
        cfg_edge_we = 1'b0;
    endtask

    task automatic load_state(input int idx, input int fail, input logic fin,
                              input logic [3:0] vec);
        cfg_state_we = 1'b1; cfg_state_idx = 5'(idx); cfg_state_fail = 5'(fail);
        cfg_state_final = fin; cfg_state_vec = vec;
        @(negedge clk);
        cfg_state_we = 1'b0;
    endtask

    // present one character at a negedge, wait until it is consumed
    task automatic push(input byte c);
        logic rdy;
        in_valid = 1'b1;
        in_data  = c;
        last_cycles = 0;
        forever begin
            #1 rdy = in_ready;
            @(negedge clk);
            last_cycles++;
            if (rdy) break;
        end
        in_valid = 1'b0;
        last_mv  = match_valid;
        last_vec = match_vec;
    endtask

    // stream a word; all but the last character must not report a match
    task automatic push_word(input string w, input string req);
        for (int i = 0; i < w.len(); i++) begin
            push(w[i]);
            if (i < w.len() - 1) chk({req, " no early match"}, last_mv, 0);
        end
    endtask

    // four patterns: abcdef, kbgdyh, wxpdem, bcx; trie states numbered along each word
    task automatic build_automaton();
        string pats [4] = '{"abcdef", "kbgdyh", "wxpdem", "bcx"};
        int nxt = 1;
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < pats[p].len(); i++) begin
                load_edge(nxt - 1, 1'b1, (i == 0) ? 0 : nxt - 1, pats[p][i], nxt);
                if (i == pats[p].len() - 1) load_state(nxt, 0, 1'b1, 4'(1 << p));
                nxt++;
            end
        end
        load_state(2, 19, 1'b0, 4'b0);   // "ab"  -> "b"
        load_state(3, 20, 1'b0, 4'b0);   // "abc" -> "bc"
        load_state(8, 19, 1'b0, 4'b0);   // "kb"  -> "b"
    endtask

    task automatic t_reset();
        chk("R1 state", cur_state, 0);
        chk("R1 match_valid", match_valid, 0);
        chk("R1 ready", in_ready, 1);
    endtask

    task automatic t_goto_and_match();
        push("a");
        chk("R2 cycles", last_cycles, 1);
        chk("R2 state", cur_state, 1);
        push_word("bcdef", "R3");
        chk("R3 match_valid", last_mv, 1);
        chk("R3 vec", last_vec, 4'b0001);
        chk("R3 state", cur_state, 6);
        @(negedge clk);
        chk("R3 one-cycle pulse", match_valid, 0);
    endtask

    task automatic t_idle();
        logic [4:0] s = cur_state;
        repeat (3) @(negedge clk);
        chk("R8 state hold", cur_state, s);
        chk("R8 ready", in_ready, 1);
        chk("R8 no match", match_valid, 0);
    endtask

    task automatic t_root_miss();
        push("z");                           // from 6: hop to 0, drop at root
        chk("R4 hop then root", last_cycles, 2);
        push("q");
        chk("R5 cycles", last_cycles, 1);
        chk("R5 state", cur_state, 0);
    endtask

    task automatic t_fail_chain();
        push_word("ab", "R4");
        push("k");                           // 2 -> 19 -> 0, then hit to 7
        chk("R4 cycles", last_cycles, 3);
        chk("R4 state", cur_state, 7);
        push("b");
        push("c");                           // 8 -> 19, hit to 20
        chk("R7 cycles", last_cycles, 2);
        chk("R7 state", cur_state, 20);
        push("x");
        chk("R7 match", last_mv, 1);
        chk("R7 vec", last_vec, 4'b1000);
        push("z");
        push_word("abc", "R6");
        push("q");                           // 3 -> 20 -> 0 -> dropped
        chk("R6 cycles", last_cycles, 3);
        chk("R6 state", cur_state, 0);
        chk("R6 no match", last_mv, 0);
    endtask

    task automatic t_vectors();
        push_word("kbgdyh", "R11");
        chk("R11 vec pattern1", last_vec, 4'b0010);
        push("q");
        push_word("wxpdem", "R11");
        chk("R11 vec pattern2", last_vec, 4'b0100);
        chk("R11 state", cur_state, 18);
        push("q");
    endtask

    task automatic t_priority();
        load_edge(41, 1'b1, 0, "z", 22);
        load_edge(40, 1'b1, 0, "z", 23);
        push("z");
        chk("R9 lowest index", cur_state, 23);
        push("q");
        chk("R9 back at root", cur_state, 0);
        load_edge(40, 1'b0, 0, "z", 23);
        push("z");
        chk("R10 dead edge skipped", cur_state, 22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        build_automaton();
        t_goto_and_match();
        t_idle();
        t_root_miss();
        t_fail_chain();
        t_vectors();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule